// File: doc/BRIEF.md
# External Interrupt Input Controller

This block conditions three external interrupt pins for a system controller. Each pin is first brought into the peripheral clock domain and then filtered, so that a short glitch never reaches the detection logic. Each channel has its own sensitivity. A run-time mode bit selects edge or level detection. A polarity bit selects which edge or which level counts as active.

A detected condition sets a sticky per-channel flag. The flags are presented directly as interrupt requests to an interrupt controller, and software clears a flag by writing a one to its bit. A second, independent path raises a per-channel wake-up request toward a wake-up timer. Only channels whose wake enable bit is set raise it, and it does not depend on the state of the flag.

Configuration and flag access use a small APB-style register port. The port has a setup phase and an access phase, has no wait states, and returns read data combinationally.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset all flags, interrupt outputs and wake outputs are 0, and all four registers read 0. The filtered pin state resets to high, so pins held high through reset raise nothing.
- R2: Each pin passes a two-flop synchronizer and then a filter that accepts a new level only after the synchronized value has differed from the filtered one on 3 consecutive clocks. A change that lasts 2 clocks is ignored. A held change sets an edge flag on the 6th rising clock edge after the pin moves, and not on the 5th.
- R3: With its mode bit at 1 (edge), a channel sets its flag on a falling filtered transition when its polarity bit is 0, and on a rising one when it is 1. The opposite transition does not set the flag.
- R4: With its mode bit at 0 (level), a channel sets its flag on every clock in which the filtered input equals its polarity bit (0 = low active, 1 = high active). While that holds, a write-one clear has no effect.
- R5: Writing to address 0 clears each flag whose data bit is 1 and leaves flags with a 0 bit unchanged. A set condition in the same cycle as a clear wins.
- R6: The register address map is: 0 = flags (bits 2:0, write-one-to-clear), 1 = wake enable, 2 = mode, 3 = polarity. Bit i belongs to channel i. Bits 7:3 of every register read as 0, and writes to them are ignored.
- R7: `wake_o[i]` is driven by a register that loads, on each clock, whether a set condition of channel i was present AND its wake enable bit was 1. In edge mode this gives a one-cycle pulse. It stays 0 while the enable bit is 0.
- R8: `irq_o` presents the flags. A set flag stays set until it is cleared by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 3 | Asynchronous external interrupt pins |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 2 | Register index |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data (combinational) |
| irq_o | output | 3 | Per-channel interrupt request (flags) |
| wake_o | output | 3 | Per-channel wake-up request |

## Verification
The bench injects a two-clock pin pulse and a three-clock pin pulse. A filter with an off-by-one window would either pass the short pulse or drop the long one. It samples the flag one clock before and one clock after the expected set edge, so an extra or missing pipeline stage is caught. It times a clear write to land on the same edge as a falling event; a design that lets the clear win loses that interrupt. It also clears a level-mode flag while the pin is still active, and checks that the opposite edge, the reserved bits and disabled wake enables all produce nothing.

// File: rtl/eirq_pkg.sv
// Shared types for the external interrupt controller.
// Assumes a two-bit register index, one register per index.
package eirq_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_FLAG = 2'd0,
        REG_WAKE = 2'd1,
        REG_MODE = 2'd2,
        REG_POL  = 2'd3
    } eirq_reg_e;

endpackage

// File: rtl/eirq_filter.sv
// Two-flop synchronizer followed by a stability filter for one pin.
// The filtered output takes a new level only after the synchronized value
// has differed from it on FILT_LEN consecutive clocks.
// Assumes pins idle high: all stages reset to 1.
module eirq_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic sync_o,
    output logic filt_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic       meta_q;
    logic       sync_q;
    logic       filt_q;
    logic [CW-1:0] cnt_q;

    // Bring the asynchronous pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
        end
    end

    // Count consecutive mismatches and accept the level once the count is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q <= 1'b1;
            cnt_q  <= '0;
        end else if (sync_q != filt_q) begin
            if (cnt_q == CW'(FILT_LEN - 1)) begin
                filt_q <= sync_q;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    assign sync_o = sync_q;
    assign filt_o = filt_q;
endmodule

// File: rtl/eirq_chan.sv
// Detection, sticky flag and wake request for one channel.
// mode_i: 1 = edge, 0 = level. pol_i: 1 = rising/high, 0 = falling/low.
// A set condition has priority over a clear in the same cycle.
module eirq_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic filt_i,
    input  logic mode_i,
    input  logic pol_i,
    input  logic wake_en_i,
    input  logic clr_i,
    output logic evt_o,
    output logic flag_o,
    output logic wake_o
);
    logic filt_d;
    logic flag_q;
    logic wake_q;
    logic rise;
    logic fall;
    logic active;
    logic set;

    // Decode the selected edge or level of the filtered input.
    always_comb begin
        rise   = filt_i & ~filt_d;
        fall   = ~filt_i & filt_d;
        evt_o  = mode_i & (pol_i ? rise : fall);
        active = ~mode_i & (filt_i == pol_i);
        set    = evt_o | active;
    end

    // Keep the previous filtered level, the sticky flag and the wake request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_d <= 1'b1;
            flag_q <= 1'b0;
            wake_q <= 1'b0;
        end else begin
            filt_d <= filt_i;
            flag_q <= set | (flag_q & ~clr_i);
            wake_q <= set & wake_en_i;
        end
    end

    assign flag_o = flag_q;
    assign wake_o = wake_q;
endmodule

// File: rtl/eirq_regs.sv
// Register port: wake enable, mode and polarity storage, flag clear strobes
// and combinational read mux. Bits above N_CH read as 0 and ignore writes.
module eirq_regs
    import eirq_pkg::*;
#(
    parameter int N_CH   = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [N_CH-1:0]   flags_i,
    output logic [N_CH-1:0]   wake_en_o,
    output logic [N_CH-1:0]   mode_o,
    output logic [N_CH-1:0]   pol_o,
    output logic [N_CH-1:0]   clr_o,
    output logic [DATA_W-1:0] prdata
);
    localparam int PAD_W = DATA_W - N_CH;

    logic            wr;
    logic [N_CH-1:0] rd_val;
    logic            unused_hi;
    eirq_reg_e       sel;

    assign sel       = eirq_reg_e'(paddr);
    assign wr        = psel & penable & pwrite;
    assign unused_hi = ^pwdata[DATA_W-1:N_CH];

    // Store configuration bits on an access-phase write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_en_o <= '0;
            mode_o    <= '0;
            pol_o     <= '0;
        end else if (wr) begin
            case (sel)
                REG_WAKE: wake_en_o <= pwdata[N_CH-1:0];
                REG_MODE: mode_o    <= pwdata[N_CH-1:0];
                REG_POL:  pol_o     <= pwdata[N_CH-1:0];
                default:  ;
            endcase
        end
    end

    // Produce the write-one-to-clear strobes and the read data.
    always_comb begin
        clr_o = (wr && sel == REG_FLAG) ? pwdata[N_CH-1:0] : '0;
        case (sel)
            REG_FLAG: rd_val = flags_i;
            REG_WAKE: rd_val = wake_en_o;
            REG_MODE: rd_val = mode_o;
            default:  rd_val = pol_o;
        endcase
        prdata = {{PAD_W{1'b0}}, rd_val};
    end
endmodule

// File: rtl/ext_irq_ctrl.sv
// External interrupt input controller: per-channel synchronizer and filter,
// edge/level detection with selectable polarity, sticky write-one-to-clear
// flags driving irq_o, and a separately enabled wake request.
// Assumes DATA_W >= N_CH and pins that idle high.
module ext_irq_ctrl
    import eirq_pkg::*;
#(
    parameter int N_CH     = 3,
    parameter int DATA_W   = 8,
    parameter int FILT_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH-1:0]   pin_i,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic [N_CH-1:0]   irq_o,
    output logic [N_CH-1:0]   wake_o
);
    logic [N_CH-1:0] sync_w;
    logic [N_CH-1:0] filt_w;
    logic [N_CH-1:0] evt_w;
    logic [N_CH-1:0] wake_en_r;
    logic [N_CH-1:0] mode_r;
    logic [N_CH-1:0] pol_r;
    logic [N_CH-1:0] clr_w;

    eirq_regs #(.N_CH(N_CH), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .pwdata    (pwdata),
        .flags_i   (irq_o),
        .wake_en_o (wake_en_r),
        .mode_o    (mode_r),
        .pol_o     (pol_r),
        .clr_o     (clr_w),
        .prdata    (prdata)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        eirq_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pin_i[i]),
            .sync_o (sync_w[i]),
            .filt_o (filt_w[i])
        );

        eirq_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .filt_i    (filt_w[i]),
            .mode_i    (mode_r[i]),
            .pol_i     (pol_r[i]),
            .wake_en_i (wake_en_r[i]),
            .clr_i     (clr_w[i]),
            .evt_o     (evt_w[i]),
            .flag_o    (irq_o[i]),
            .wake_o    (wake_o[i])
        );
    end
endmodule

// File: rtl/eirq_chk.sv
// Property checker for ext_irq_ctrl, attached by bind below.
// Observes ports plus the filter, event and configuration signals.
module eirq_chk
    import eirq_pkg::*;
#(
    parameter int N_CH   = 3,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [DATA_W-1:0] pwdata,
    input logic [DATA_W-1:0] prdata,
    input logic [N_CH-1:0]   irq_o,
    input logic [N_CH-1:0]   wake_o,
    input logic [N_CH-1:0]   sync_w,
    input logic [N_CH-1:0]   filt_w,
    input logic [N_CH-1:0]   evt_w,
    input logic [N_CH-1:0]   mode_r,
    input logic [N_CH-1:0]   pol_r,
    input logic [N_CH-1:0]   wake_en_r
);
    logic flag_wr;
    assign flag_wr = psel && penable && pwrite && paddr == REG_FLAG;

    a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        prdata[DATA_W-1:N_CH] == '0);

    for (genvar i = 0; i < N_CH; i++) begin : g_p
        a_r2_filter_from_sync: assert property (@(posedge clk) disable iff (!rst_n)
            filt_w[i] != $past(filt_w[i]) |-> filt_w[i] == $past(sync_w[i]));

        a_r3_edge_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
            evt_w[i] |=> irq_o[i]);

        a_r4_level_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode_r[i] && filt_w[i] == pol_r[i]) |=> irq_o[i]);

        a_r5_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_wr && pwdata[i] && mode_r[i] && !evt_w[i]) |=> !irq_o[i]);

        a_r7_wake_gated: assert property (@(posedge clk) disable iff (!rst_n)
            !wake_en_r[i] |=> !wake_o[i]);

        a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_o[i] && !(flag_wr && pwdata[i])) |=> irq_o[i]);
    end
endmodule

bind ext_irq_ctrl eirq_chk #(.N_CH(N_CH), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .pwdata    (pwdata),
    .prdata    (prdata),
    .irq_o     (irq_o),
    .wake_o    (wake_o),
    .sync_w    (sync_w),
    .filt_w    (filt_w),
    .evt_w     (evt_w),
    .mode_r    (mode_r),
    .pol_r     (pol_r),
    .wake_en_r (wake_en_r)
);

// File: tb/tb_ext_irq_ctrl.sv
// Scoreboard bench: apb_read pushes expected read data into a queue and the
// monitor pops and compares it during the access phase. Output checks go
// through the same counters.
module tb_ext_irq_ctrl;
    import eirq_pkg::*;

    typedef struct {
        logic [7:0] val;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] pin_i = 3'b111;
    logic       psel = 1'b0;
    logic       penable = 1'b0;
    logic       pwrite = 1'b0;
    logic [1:0] paddr = '0;
    logic [7:0] pwdata = '0;
    logic [7:0] prdata;
    logic [2:0] irq_o;
    logic [2:0] wake_o;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    ext_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
        .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .irq_o(irq_o), .wake_o(wake_o)
    );

    task automatic compare(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Monitor: pop one expected item per read access phase.
    always @(negedge clk) begin
        if (psel && penable && !pwrite) begin
            if (exp_q.size() == 0) begin
                compare("SCOREBOARD_EMPTY", 8'h01, 8'h00);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                compare(e.req, prdata, e.val);
            end
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic apb_write(logic [1:0] a, logic [7:0] d);
        @(posedge clk); #1;
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(posedge clk); #1;
        penable = 1'b1;
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(logic [1:0] a, logic [7:0] e, string req);
        exp_t it;
        it.val = e;
        it.req = req;
        exp_q.push_back(it);
        @(posedge clk); #1;
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(posedge clk); #1;
        penable = 1'b1;
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic see(string req, logic [2:0] act, logic [2:0] exp);
        compare(req, {5'b0, act}, {5'b0, exp});
    endtask

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(1);
        // R1 reset state
        see("R1 irq", irq_o, 3'b000);
        see("R1 wake", wake_o, 3'b000);
        apb_read(REG_FLAG, 8'h00, "R1 flag reg");
        apb_read(REG_WAKE, 8'h00, "R1 wake reg");
        apb_read(REG_MODE, 8'h00, "R1 mode reg");
        apb_read(REG_POL,  8'h00, "R1 pol reg");
        wait_cyc(10);
        see("R1 idle high no flag", irq_o, 3'b000);

        // R6 map and reserved bits
        apb_write(REG_MODE, 8'hFF);
        apb_read(REG_MODE, 8'h07, "R6 mode reserved");
        apb_write(REG_POL, 8'hFF);
        apb_read(REG_POL, 8'h07, "R6 pol reserved");
        apb_write(REG_POL, 8'h02);
        apb_read(REG_POL, 8'h02, "R6 pol readback");
        apb_write(REG_WAKE, 8'h01);
        apb_read(REG_WAKE, 8'h01, "R6 wake readback");
        apb_read(REG_FLAG, 8'h00, "R6 flags untouched");

        // R2 glitch of two clocks is dropped
        pin_i[0] = 1'b0; wait_cyc(2); pin_i[0] = 1'b1; wait_cyc(8);
        see("R2 short pulse", irq_o, 3'b000);
        // R2 three clock pulse passes
        pin_i[0] = 1'b0; wait_cyc(3); pin_i[0] = 1'b1; wait_cyc(8);
        see("R2 long pulse", irq_o, 3'b001);
        apb_write(REG_FLAG, 8'h01);
        see("R5 clear", irq_o, 3'b000);

        // R2 latency, R3 falling edge, R7 wake pulse, R8 sticky
        pin_i[0] = 1'b0; wait_cyc(5);
        see("R2 not yet", irq_o, 3'b000);
        wait_cyc(1);
        see("R3 falling sets", irq_o, 3'b001);
        see("R7 wake pulse", wake_o, 3'b001);
        wait_cyc(1);
        see("R7 pulse ends", wake_o, 3'b000);
        wait_cyc(5);
        see("R8 sticky", irq_o, 3'b001);
        apb_write(REG_FLAG, 8'h01);
        pin_i[0] = 1'b1; wait_cyc(8);
        see("R3 rising ignored pol0", irq_o, 3'b000);

        // R3 channel 1 rising, R7 wake disabled
        pin_i[1] = 1'b0; wait_cyc(8);
        see("R3 falling ignored pol1", irq_o, 3'b000);
        pin_i[1] = 1'b1; wait_cyc(6);
        see("R3 rising sets pol1", irq_o, 3'b010);
        see("R7 wake disabled", wake_o, 3'b000);

        // R5 partial clear
        pin_i[0] = 1'b0; wait_cyc(8);
        see("R5 two flags", irq_o, 3'b011);
        apb_write(REG_FLAG, 8'h02);
        see("R5 zero bit keeps", irq_o, 3'b001);
        apb_read(REG_FLAG, 8'h01, "R5 flag readback");

        // R5 set wins over clear on the same edge
        pin_i[0] = 1'b1; wait_cyc(8);
        pin_i[0] = 1'b0; wait_cyc(3);
        apb_write(REG_FLAG, 8'h01);
        see("R5 set wins", irq_o, 3'b001);
        apb_write(REG_FLAG, 8'h01);
        see("R5 clear after", irq_o, 3'b000);

        // R4 level mode, low active, pin still low
        apb_write(REG_MODE, 8'h06);
        wait_cyc(1);
        see("R4 level sets", irq_o, 3'b001);
        see("R7 level wake", wake_o, 3'b001);
        apb_write(REG_FLAG, 8'h01);
        see("R4 clear ignored", irq_o, 3'b001);
        apb_read(REG_FLAG, 8'h01, "R4 flag readback");
        pin_i[0] = 1'b1; wait_cyc(6);
        see("R7 wake drops", wake_o, 3'b000);
        see("R8 held after inactive", irq_o, 3'b001);
        apb_write(REG_FLAG, 8'h01);
        see("R4 clear when inactive", irq_o, 3'b000);
        wait_cyc(3);
        see("R4 stays clear", irq_o, 3'b000);

        wait_cyc(2);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL WATCHDOG: actual running expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule